// File: doc/BRIEF.md
# Stack Push/Pop Bound Checker

This block decides whether a stack push or a stack pop of two or four bytes is legal, given the attributes of the current stack segment and the stack pointer. It is used by an execution pipeline before any stack access. The pipeline presents the segment attributes, the pointer, the access length, the direction and the operating mode. One cycle later the block returns a single pass/fail bit. Choosing and raising the fault, updating the pointer and doing the memory access are all left to the caller.

Outside protected mode every access passes. In protected mode the segment must be usable, and it must be a writable data segment. The bound rules then depend on the direction and on whether the segment grows up or down. A segment with a 16-bit size attribute uses only the low half of the pointer and a ceiling of 0xFFFF. A 32-bit segment uses the whole pointer and a ceiling of 0xFFFFFFFF. All arithmetic is modulo 2^32.

Top module: `stk_bound_chk`

## Requirements
- R1: When `inPm` is 0, `okQ` is 1 in the cycle after the inputs are presented, whatever the other inputs are.
- R2: In protected mode, `okQ` goes to 0 if `segValid` is 0 or `segPresent` is 0.
- R3: In protected mode, `okQ` goes to 0 if `segIsData` is 0 (a system segment), if `segIsCode` is 1, or if `segWritable` is 0.
- R4: When `segBig` is 0, bits 31..16 of `stkPtr` are ignored and the ceiling is 0xFFFF. When `segBig` is 1, the ceiling is 0xFFFFFFFF. `lenIsFour` selects the length: 0 means 2 bytes and 1 means 4 bytes.
- R5: A push (`isPush`=1) on a segment that grows down (`segGrowDown`=1) fails if any one of these holds: the pointer is 0, the pointer is below the length, pointer minus length is at or below `segLimit`, or the pointer is above the ceiling.
- R6: A push on a segment that grows up, with a pointer of 0, passes only if `segEnd` equals the ceiling.
- R7: A push on a segment that grows up, with a nonzero pointer, fails if the pointer is below the length or if pointer minus 1 is above `segLimit`.
- R8: A pop (`isPush`=0) on a segment that grows down fails if the pointer equals the ceiling, or if ceiling minus pointer plus 1 is below the length.
- R9: A pop on a segment that grows up fails if any one of these holds: the pointer equals the ceiling, `segEnd` is 0, the pointer is above `segLimit`, or `segLimit` minus pointer plus 1 (modulo 2^32) is below the length.
- R10: The result is registered once, so `okQ` reflects the inputs of the previous clock edge. Reset drives `okQ` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inPm | input | 1 | Protected mode active |
| isPush | input | 1 | 1 = push, 0 = pop |
| lenIsFour | input | 1 | Access length: 0 = 2 bytes, 1 = 4 bytes |
| segValid | input | 1 | Segment attributes are valid |
| segPresent | input | 1 | Segment is present |
| segIsData | input | 1 | 1 = code/data segment, 0 = system segment |
| segIsCode | input | 1 | Segment is a code segment |
| segWritable | input | 1 | Segment is writable |
| segGrowDown | input | 1 | Segment grows downward |
| segBig | input | 1 | 32-bit size attribute |
| segLimit | input | 32 | Segment limit |
| segEnd | input | 32 | Segment end address |
| stkPtr | input | 32 | Stack pointer |
| okQ | output | 1 | Registered pass (1) / fail (0) |

## Verification
Directed vectors place the pointer exactly on each rule's edge: zero, the length, limit plus length, and the ceiling. They separate off-by-one errors in the comparisons and show which length is in use. A 16-bit vector with junk in the upper pointer bits separates masked handling from unmasked handling. Random vectors draw the pointer near the limit, near the ceiling, at zero, or anywhere, and `segEnd` at the ceiling, at zero, or random. Together these exercise all four direction/growth rules and the attribute gate, including the wrap-around of the limit arithmetic.

// File: rtl/stk_chk_pkg.sv
package stk_chk_pkg;

  // Strobes from the control decode to the bound datapath.
  typedef struct packed {
    logic bypass;    // not in protected mode: always pass
    logic attrFail;  // attribute gate rejects the segment
    logic doPush;    // push rule set, else pop
    logic growDown;  // expand-down rule set
    logic wide;      // 32-bit pointer and ceiling
    logic lenFour;   // four-byte access
  } stkStrobes_t;

endpackage

// File: rtl/stk_chk_ctrl.sv
module stk_chk_ctrl
  import stk_chk_pkg::*;
(
  input  logic        inPm,
  input  logic        isPush,
  input  logic        lenIsFour,
  input  logic        segValid,
  input  logic        segPresent,
  input  logic        segIsData,
  input  logic        segIsCode,
  input  logic        segWritable,
  input  logic        segGrowDown,
  input  logic        segBig,
  output stkStrobes_t strobes
);

  logic unusable;
  logic wrongKind;

  always_comb begin
    unusable  = !segValid || !segPresent;
    wrongKind = !segIsData || segIsCode || !segWritable;

    strobes.bypass   = !inPm;
    strobes.attrFail = unusable || wrongKind;
    strobes.doPush   = isPush;
    strobes.growDown = segGrowDown;
    strobes.wide     = segBig;
    strobes.lenFour  = lenIsFour;
  end

endmodule

// File: rtl/stk_chk_dpath.sv
module stk_chk_dpath
  import stk_chk_pkg::*;
#(
  parameter int AW = 32,
  parameter int NW = 16
) (
  input  stkStrobes_t   strobes,
  input  logic [AW-1:0] stkPtr,
  input  logic [AW-1:0] segLimit,
  input  logic [AW-1:0] segEnd,
  output logic          boundFail
);

  localparam logic [AW-1:0] ALL_ONES   = '1;
  localparam logic [AW-1:0] NARROW_TOP = {{(AW-NW){1'b0}}, {NW{1'b1}}};
  localparam logic [AW-1:0] ONE        = AW'(1);
  localparam logic [AW-1:0] LEN_SHORT  = AW'(2);
  localparam logic [AW-1:0] LEN_LONG   = AW'(4);

  logic [AW-1:0] ptrM;
  logic [AW-1:0] ceilV;
  logic [AW-1:0] lenV;
  logic          ptrZero;
  logic          ptrAtCeil;

  always_comb begin
    ptrM      = strobes.wide ? stkPtr : (stkPtr & NARROW_TOP);
    ceilV     = strobes.wide ? ALL_ONES : NARROW_TOP;
    lenV      = strobes.lenFour ? LEN_LONG : LEN_SHORT;
    ptrZero   = (ptrM == '0);
    ptrAtCeil = (ptrM == ceilV);
  end

  // One rule per direction/growth pair.
  logic pushDownFail;
  logic pushUpFail;
  logic popDownFail;
  logic popUpFail;

  always_comb begin
    pushDownFail = ptrZero || (ptrM < lenV) ||
                   ((ptrM - lenV) <= segLimit) || (ptrM > ceilV);
  end

  always_comb begin
    if (ptrZero) pushUpFail = (segEnd != ceilV);
    else         pushUpFail = (ptrM < lenV) || ((ptrM - ONE) > segLimit);
  end

  always_comb begin
    popDownFail = ptrAtCeil || (((ceilV - ptrM) + ONE) < lenV);
  end

  always_comb begin
    popUpFail = ptrAtCeil || (segEnd == '0) || (ptrM > segLimit) ||
                (((segLimit - ptrM) + ONE) < lenV);
  end

  always_comb begin
    unique case ({strobes.doPush, strobes.growDown})
      2'b11:   boundFail = pushDownFail;
      2'b10:   boundFail = pushUpFail;
      2'b01:   boundFail = popDownFail;
      default: boundFail = popUpFail;
    endcase
  end

endmodule

// File: rtl/stk_bound_chk.sv
module stk_bound_chk
  import stk_chk_pkg::*;
#(
  parameter int AW = 32,
  parameter int NW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inPm,
  input  logic          isPush,
  input  logic          lenIsFour,
  input  logic          segValid,
  input  logic          segPresent,
  input  logic          segIsData,
  input  logic          segIsCode,
  input  logic          segWritable,
  input  logic          segGrowDown,
  input  logic          segBig,
  input  logic [AW-1:0] segLimit,
  input  logic [AW-1:0] segEnd,
  input  logic [AW-1:0] stkPtr,
  output logic          okQ
);

  localparam logic [AW-1:0] NARROW_MASK = {{(AW-NW){1'b0}}, {NW{1'b1}}};

  stkStrobes_t strobes;
  logic        boundFail;
  logic        okNext;

  stk_chk_ctrl u_ctrl (
    .inPm       (inPm),
    .isPush     (isPush),
    .lenIsFour  (lenIsFour),
    .segValid   (segValid),
    .segPresent (segPresent),
    .segIsData  (segIsData),
    .segIsCode  (segIsCode),
    .segWritable(segWritable),
    .segGrowDown(segGrowDown),
    .segBig     (segBig),
    .strobes    (strobes)
  );

  stk_chk_dpath #(.AW(AW), .NW(NW)) u_dpath (
    .strobes  (strobes),
    .stkPtr   (stkPtr),
    .segLimit (segLimit),
    .segEnd   (segEnd),
    .boundFail(boundFail)
  );

  always_comb okNext = strobes.bypass || (!strobes.attrFail && !boundFail);

  always_ff @(posedge clk) begin
    if (!rstN) okQ <= 1'b0;
    else       okQ <= okNext;
  end

  // R1
  real_mode_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inPm |=> okQ);

  // R2
  unusable_seg_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inPm && (!segValid || !segPresent)) |=> !okQ);

  // R3
  wrong_kind_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inPm && (!segIsData || segIsCode || !segWritable)) |=> !okQ);

  // R5
  push_down_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inPm && isPush && segGrowDown &&
     ((segBig ? stkPtr : (stkPtr & NARROW_MASK)) == '0)) |=> !okQ);

  // R8
  pop_at_ceiling_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inPm && !isPush && (segBig ? (stkPtr == '1) :
     ((stkPtr & NARROW_MASK) == NARROW_MASK))) |=> !okQ);

endmodule

// File: tb/stk_bound_chk_tb.sv
module stk_bound_chk_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int N_RANDOM   = 4000;

  logic        clk = 1'b0;
  logic        rstN;
  logic        inPm, isPush, lenIsFour;
  logic        segValid, segPresent, segIsData, segIsCode, segWritable;
  logic        segGrowDown, segBig;
  logic [31:0] segLimit, segEnd, stkPtr;
  logic        okQ;

  int nVec  = 0;
  int nMiss = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stk_bound_chk dut_i (
    .clk(clk), .rstN(rstN), .inPm(inPm), .isPush(isPush), .lenIsFour(lenIsFour),
    .segValid(segValid), .segPresent(segPresent), .segIsData(segIsData),
    .segIsCode(segIsCode), .segWritable(segWritable), .segGrowDown(segGrowDown),
    .segBig(segBig), .segLimit(segLimit), .segEnd(segEnd), .stkPtr(stkPtr),
    .okQ(okQ)
  );

  // Expected result from the requirement text.
  function automatic logic expectOk();
    logic [31:0] p, c, n;
    if (!inPm) return 1'b1;                                          // R1
    if (!segValid || !segPresent) return 1'b0;                       // R2
    if (!segIsData || segIsCode || !segWritable) return 1'b0;        // R3
    c = segBig ? 32'hFFFF_FFFF : 32'h0000_FFFF;                      // R4
    p = segBig ? stkPtr : {16'h0, stkPtr[15:0]};
    n = lenIsFour ? 32'd4 : 32'd2;
    if (isPush && segGrowDown)                                       // R5
      return !(p == 0 || p < n || (p - n) <= segLimit || p > c);
    if (isPush && p == 0) return segEnd == c;                        // R6
    if (isPush) return !(p < n || (p - 32'd1) > segLimit);           // R7
    if (segGrowDown) return !(p == c || (c - p + 32'd1) < n);        // R8
    return !(p == c || segEnd == 0 || p > segLimit ||                // R9
             (segLimit - p + 32'd1) < n);
  endfunction

  function automatic string ruleTag();
    if (!inPm) return "R1";
    if (!segValid || !segPresent) return "R2";
    if (!segIsData || segIsCode || !segWritable) return "R3";
    if (isPush && segGrowDown) return "R5";
    if (isPush) return ((segBig ? stkPtr : {16'h0, stkPtr[15:0]}) == 0) ? "R6" : "R7";
    return segGrowDown ? "R8" : "R9";
  endfunction

  task automatic goodSeg();
    inPm = 1; segValid = 1; segPresent = 1; segIsData = 1;
    segIsCode = 0; segWritable = 1;
  endtask

  task automatic judge(input logic exp, input string tag);
    nVec++;
    if (okQ !== exp) begin
      nMiss++;
      $display("FAIL %s: okQ=%b expected=%b ptr=%h lim=%h end=%h push=%b down=%b big=%b len4=%b",
               tag, okQ, exp, stkPtr, segLimit, segEnd, isPush, segGrowDown, segBig, lenIsFour);
    end
  endtask

  // Inputs already set at a falling edge; result visible one edge later (R10).
  task automatic applyCheck(input logic exp, input string tag);
    @(posedge clk);
    @(negedge clk);
    judge(exp, tag);
  endtask

  task automatic setVec(input logic push, input logic down, input logic big,
                        input logic len4, input logic [31:0] lim,
                        input logic [31:0] segE, input logic [31:0] ptr);
    goodSeg();
    isPush = push; segGrowDown = down; segBig = big; lenIsFour = len4;
    segLimit = lim; segEnd = segE; stkPtr = ptr;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nMiss++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nMiss);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rstN = 0;
    setVec(1, 0, 1, 0, 32'h100, 32'h0, 32'h10);
    inPm = 0;
    @(negedge clk); @(negedge clk);
    judge(1'b0, "R10 reset");
    rstN = 1;

    // Directed corners
    @(negedge clk);
    setVec(1, 1, 1, 1, 32'h0, 32'h0, 32'h0); segValid = 0; inPm = 0;
    applyCheck(1'b1, "R1 real mode ignores attributes");
    setVec(1, 0, 1, 0, 32'hFFFF, 32'hFFFF, 32'h100); segPresent = 0;
    applyCheck(1'b0, "R2 not present");
    setVec(1, 0, 1, 0, 32'hFFFF, 32'hFFFF, 32'h100); segValid = 0;
    applyCheck(1'b0, "R2 invalid");
    setVec(0, 0, 1, 0, 32'hFFFF, 32'hFFFF, 32'h100); segIsData = 0;
    applyCheck(1'b0, "R3 system segment");
    setVec(0, 0, 1, 0, 32'hFFFF, 32'hFFFF, 32'h100); segIsCode = 1;
    applyCheck(1'b0, "R3 code segment");
    setVec(0, 0, 1, 0, 32'hFFFF, 32'hFFFF, 32'h100); segWritable = 0;
    applyCheck(1'b0, "R3 read-only");
    setVec(0, 0, 0, 0, 32'hFFFF, 32'h1, 32'h1234_0000);
    applyCheck(1'b1, "R4 upper pointer bits ignored");
    setVec(1, 1, 1, 0, 32'h100, 32'h0, 32'h0);
    applyCheck(1'b0, "R5 push down pointer zero");
    setVec(1, 1, 1, 1, 32'h100, 32'h0, 32'h104);
    applyCheck(1'b0, "R5 push down lands on limit");
    setVec(1, 1, 1, 1, 32'h100, 32'h0, 32'h105);
    applyCheck(1'b1, "R5 push down one above limit");
    setVec(1, 0, 0, 0, 32'h1000, 32'hFFFF, 32'hABCD_0000);
    applyCheck(1'b1, "R6 push up zero with end at 16-bit ceiling");
    setVec(1, 0, 1, 0, 32'h1000, 32'hFFFF, 32'h0);
    applyCheck(1'b0, "R6 push up zero with end below 32-bit ceiling");
    setVec(1, 0, 1, 0, 32'h1000, 32'h0, 32'h1);
    applyCheck(1'b0, "R7 push up pointer below length");
    setVec(1, 0, 1, 0, 32'h1000, 32'h0, 32'h1001);
    applyCheck(1'b1, "R7 push up pointer-1 at limit");
    setVec(1, 0, 1, 0, 32'h1000, 32'h0, 32'h1002);
    applyCheck(1'b0, "R7 push up pointer-1 above limit");
    setVec(0, 1, 0, 1, 32'h10, 32'h0, 32'hFFFE);
    applyCheck(1'b0, "R8 pop down two bytes left, four asked");
    setVec(0, 1, 0, 0, 32'h10, 32'h0, 32'hFFFE);
    applyCheck(1'b1, "R8 pop down two bytes left, two asked");
    setVec(0, 1, 1, 0, 32'h10, 32'h0, 32'hFFFF_FFFF);
    applyCheck(1'b0, "R8 pop down at ceiling");
    setVec(0, 0, 1, 1, 32'h100, 32'h0, 32'h10);
    applyCheck(1'b0, "R9 pop up segment end zero");
    setVec(0, 0, 1, 1, 32'h100, 32'h5, 32'hFE);
    applyCheck(1'b0, "R9 pop up three bytes left, four asked");
    setVec(0, 0, 1, 1, 32'h100, 32'h5, 32'hFD);
    applyCheck(1'b1, "R9 pop up four bytes left");
    setVec(0, 0, 1, 0, 32'hFFFF_FFFF, 32'h5, 32'h0);
    applyCheck(1'b0, "R9 pop up limit arithmetic wraps");

    // Random vectors biased toward the edges
    for (int i = 0; i < N_RANDOM; i++) begin
      logic [31:0] ceilR;
      goodSeg();
      inPm        = ($urandom % 10) != 0;
      segValid    = ($urandom % 12) != 0;
      segPresent  = ($urandom % 12) != 0;
      segIsData   = ($urandom % 12) != 0;
      segIsCode   = ($urandom % 12) == 0;
      segWritable = ($urandom % 12) != 0;
      isPush      = $urandom % 2;
      segGrowDown = $urandom % 2;
      segBig      = $urandom % 2;
      lenIsFour   = $urandom % 2;
      ceilR       = segBig ? 32'hFFFF_FFFF : 32'h0000_FFFF;
      segLimit    = (($urandom % 2) != 0) ? ($urandom & ceilR) : ($urandom % 64);
      case ($urandom % 3)
        0:       segEnd = ceilR;
        1:       segEnd = 32'h0;
        default: segEnd = $urandom;
      endcase
      case ($urandom % 4)
        0:       stkPtr = segLimit + ($urandom % 8) - 3;
        1:       stkPtr = ceilR - ($urandom % 6) + (($urandom % 2) != 0 ? 32'hABC0_0000 : 32'h0);
        2:       stkPtr = ($urandom % 2 != 0) ? 32'h0 : ($urandom % 5);
        default: stkPtr = $urandom;
      endcase
      applyCheck(expectOk(), ruleTag());
    end

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nMiss);
    $finish;
  end

endmodule